// File: doc/BRIEF.md
# Banked Data Address Space Decoder

This block sits between a small 8-bit core and the 256-byte data space that the core addresses. Each access is sorted by address into one of four regions. The lowest quarter is empty. The second quarter is a 64-byte window into program memory, and a bank register chooses which 64-byte slice of program memory that window shows. The third quarter is on-chip general-purpose RAM. The top quarter holds the peripheral registers, the bank register itself and the accumulator.

The core drives an address and, optionally, a write strobe with data. The decoder forms the program-memory address for the window in the same cycle, so that a synchronous program memory returns its byte one cycle later. It asserts a peripheral select for the peripheral registers. One cycle after the access it presents the read data from whichever region was hit. The bottom four RAM bytes serve the core as its X, Y, V and W registers. The accumulator is a register inside the decoder that the core can also reach at the top address.

Top module: `dspace_decoder`

## Requirements
- R1: A read of an address 0x00 to 0x3F returns 0xFF one cycle later. A write there changes no RAM byte, not the bank register and not the accumulator.
- R2: In every cycle, win_addr equals {bank, addr[5:0]}. A read of 0x40 to 0x7F returns pmem_rdata in the next cycle, as sampled in that cycle.
- R3: A write to 0x40 to 0x7F is ignored: the bank register, the RAM and later window reads are unchanged.
- R4: Addresses 0x80 to 0xBF are 64 bytes of RAM. A read returns the stored byte one cycle later. A read in the same cycle as a write to that address returns the value held before the write.
- R5: The four RAM bytes 0x80, 0x81, 0x82 and 0x83 (X, Y, V, W) each hold their own value independently of the others.
- R6: The bank register (6 bits) is at address 0xC8 and reads back zero-extended to 8 bits. A write stores wr_data[5:0]. The new bank appears on win_addr from the next cycle's access onward.
- R7: The accumulator is at address 0xFF. A write stores the byte, and a later read returns it one cycle after that read.
- R8: per_sel is 1 in the access cycle exactly for addresses 0xC0 to 0xFE other than 0xC8. A read of such an address returns per_rdata one cycle later.
- R9: After synchronous reset, rd_data is 0xFF, the bank register is 0 and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Data address of the current access |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 8 | Write data |
| pmem_rdata | input | 8 | Program-memory byte for the previous cycle's win_addr |
| per_rdata | input | 8 | Peripheral read byte for the previous cycle's access |
| rd_data | output | 8 | Read data for the previous cycle's access |
| win_addr | output | 12 | Program-memory address for the window |
| per_sel | output | 1 | Current access targets a peripheral register |

## Verification
The hardest case to reach is the bank change at the very next access. A window read must be issued in the cycle directly after a bank write, with no idle cycle between them. Only then is it shown that the new bank, and not a stale one, reaches both win_addr and the returned byte. The stimulus does this with back-to-back accesses, using a program-memory model whose byte depends on every address bit. Ignored writes are proven from the ports by targeting addresses whose low six bits alias a RAM byte that was written earlier, then reading that byte and the bank back.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_WIN,
    RG_RAM,
    RG_PER,
    RG_BANK,
    RG_ACC
  } region_e;
endpackage

// File: rtl/dsd_region.sv
module dsd_region
  import dsd_pkg::*;
#(
  parameter logic [7:0] BANK_ADDR = 8'hC8,
  parameter logic [7:0] ACC_ADDR  = 8'hFF
) (
  input  logic [7:0] addr,
  output region_e    region,
  output logic       per_sel
);
  always_comb begin
    unique case (addr[7:6])
      2'b00:   region = RG_NONE;
      2'b01:   region = RG_WIN;
      2'b10:   region = RG_RAM;
      default: begin
        if (addr == ACC_ADDR)       region = RG_ACC;
        else if (addr == BANK_ADDR) region = RG_BANK;
        else                        region = RG_PER;
      end
    endcase
  end

  assign per_sel = (region == RG_PER);
endmodule

// File: rtl/dsd_ram.sv
module dsd_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single port, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/dsd_core_regs.sv
module dsd_core_regs #(
  parameter int DATA_W = 8,
  parameter int BANK_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_bank,
  input  logic              we_acc,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank,
  output logic [DATA_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
      acc  <= '0;
    end else begin
      if (we_bank) bank <= wdata[BANK_W-1:0];
      if (we_acc)  acc  <= wdata;
    end
  end
endmodule

// File: rtl/dspace_decoder.sv
module dspace_decoder
  import dsd_pkg::*;
#(
  parameter int         DATA_W    = 8,
  parameter int         BANK_W    = 6,
  parameter int         OFF_W     = 6,
  parameter logic [7:0] BANK_ADDR = 8'hC8,
  parameter logic [7:0] ACC_ADDR  = 8'hFF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [7:0]              addr,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [DATA_W-1:0]       pmem_rdata,
  input  logic [DATA_W-1:0]       per_rdata,
  output logic [DATA_W-1:0]       rd_data,
  output logic [BANK_W+OFF_W-1:0] win_addr,
  output logic                    per_sel
);
  localparam int RAM_DEPTH = 1 << OFF_W;

  region_e           rg, rg_q;
  logic [BANK_W-1:0] bank;
  logic [DATA_W-1:0] acc, core_q, ram_q, bank_ext;

  dsd_region #(
    .BANK_ADDR(BANK_ADDR),
    .ACC_ADDR (ACC_ADDR)
  ) u_region (
    .addr   (addr),
    .region (rg),
    .per_sel(per_sel)
  );

  dsd_ram #(
    .DEPTH (RAM_DEPTH),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (wr_en && (rg == RG_RAM)),
    .addr (addr[OFF_W-1:0]),
    .wdata(wr_data),
    .rdata(ram_q)
  );

  dsd_core_regs #(
    .DATA_W(DATA_W),
    .BANK_W(BANK_W)
  ) u_core (
    .clk    (clk),
    .rst    (rst),
    .we_bank(wr_en && (rg == RG_BANK)),
    .we_acc (wr_en && (rg == RG_ACC)),
    .wdata  (wr_data),
    .bank   (bank),
    .acc    (acc)
  );

  assign bank_ext = DATA_W'(bank);
  assign win_addr = {bank, addr[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rg_q   <= RG_NONE;
      core_q <= '0;
    end else begin
      rg_q   <= rg;
      core_q <= (rg == RG_ACC) ? acc : bank_ext;
    end
  end

  always_comb begin
    unique case (rg_q)
      RG_WIN:  rd_data = pmem_rdata;
      RG_RAM:  rd_data = ram_q;
      RG_PER:  rd_data = per_rdata;
      RG_BANK: rd_data = core_q;
      RG_ACC:  rd_data = core_q;
      default: rd_data = '1;
    endcase
  end
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int         DATA_W    = 8,
  parameter int         BANK_W    = 6,
  parameter int         OFF_W     = 6,
  parameter logic [7:0] BANK_ADDR = 8'hC8,
  parameter logic [7:0] ACC_ADDR  = 8'hFF
) (
  input logic                    clk,
  input logic                    rst,
  input logic [7:0]              addr,
  input logic                    wr_en,
  input logic [DATA_W-1:0]       wr_data,
  input logic [DATA_W-1:0]       pmem_rdata,
  input logic [DATA_W-1:0]       rd_data,
  input logic [BANK_W+OFF_W-1:0] win_addr,
  input logic                    per_sel
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_unimpl_ff_R1: assert property (@(posedge clk) disable iff (rst)
    (addr[7:6] == 2'b00) |=> (rd_data == '1));

  assert_window_data_R2: assert property (@(posedge clk) disable iff (rst)
    (addr[7:6] == 2'b01) |=> (rd_data == pmem_rdata));

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(wr_en && (addr == BANK_ADDR)))
      |-> $stable(win_addr[BANK_W+OFF_W-1:OFF_W]));

  assert_per_range_R8: assert property (@(posedge clk) disable iff (rst)
    per_sel |-> ((addr[7:6] == 2'b11) && (addr != ACC_ADDR) && (addr != BANK_ADDR)));

  assert_acc_roundtrip_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ACC_ADDR)) ##1 (addr == ACC_ADDR)
      |=> (rd_data == $past(wr_data, 2)));

  assert_ram_roundtrip_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr[7:6] == 2'b10)) ##1 (addr == $past(addr))
      |=> (rd_data == $past(wr_data, 2)));
endmodule

bind dspace_decoder dsd_checker #(
  .DATA_W   (DATA_W),
  .BANK_W   (BANK_W),
  .OFF_W    (OFF_W),
  .BANK_ADDR(BANK_ADDR),
  .ACC_ADDR (ACC_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .pmem_rdata(pmem_rdata),
  .rd_data   (rd_data),
  .win_addr  (win_addr),
  .per_sel   (per_sel)
);

// File: tb/dspace_decoder_test.sv
`timescale 1ns/1ps
module dspace_decoder_test;
  localparam logic [7:0] BANK_A = 8'hC8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  pmem_rdata = 8'h00;
  logic [7:0]  per_rdata = 8'h00;
  logic [7:0]  rd_data;
  logic [11:0] win_addr;
  logic        per_sel;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  bit         chk_q[$];
  string      tag_q[$];

  logic [5:0] bank_m = 6'h00;
  logic [7:0] acc_m = 8'h00;
  logic [7:0] ram_m [64];
  bit         ram_v [64];

  always #4 clk = ~clk;

  dspace_decoder uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .pmem_rdata(pmem_rdata), .per_rdata(per_rdata), .rd_data(rd_data),
    .win_addr(win_addr), .per_sel(per_sel)
  );

  function automatic logic [7:0] rom_fn(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  // synchronous program memory and peripheral models
  always @(posedge clk) begin
    pmem_rdata <= rom_fn(win_addr);
    per_rdata  <= ~addr;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] a, input bit we, input logic [7:0] d, input string tag);
    logic [7:0] e;
    bit c;
    bit ps;
    @(negedge clk);
    addr = a; wr_en = we; wr_data = d;
    c = 1'b1;
    if (a < 8'h40)       e = 8'hFF;
    else if (a < 8'h80)  e = rom_fn({bank_m, a[5:0]});
    else if (a < 8'hC0) begin e = ram_m[a[5:0]]; c = ram_v[a[5:0]]; end
    else if (a == 8'hFF) e = acc_m;
    else if (a == BANK_A) e = {2'b00, bank_m};
    else                 e = ~a;
    exp_q.push_back(e); chk_q.push_back(c); tag_q.push_back(tag);
    ps = (a >= 8'hC0) && (a != 8'hFF) && (a != BANK_A);
    #1;
    check("R2 win_addr", {4'h0, win_addr[11:4]}, {4'h0, bank_m, a[5:4]});
    check("R2 win_addr low", {4'h0, win_addr[3:0]}, {4'h0, a[3:0]});
    check("R8 per_sel", {7'h0, per_sel}, {7'h0, ps});
    if (we) begin
      if (a >= 8'h80 && a < 8'hC0) begin ram_m[a[5:0]] = d; ram_v[a[5:0]] = 1'b1; end
      else if (a == 8'hFF) acc_m = d;
      else if (a == BANK_A) bank_m = d[5:0];
    end
  endtask

  // monitor: pops one expected item per access, shortly after its edge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      bit c;
      string t;
      #2;
      e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
      if (c) check(t, rd_data, e);
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) ram_v[i] = 1'b0;
    addr = 8'h90;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 rd_data after reset", rd_data, 8'hFF);
    rst = 1'b0;
    access(BANK_A, 1'b0, 8'h00, "R9 bank reset");
    access(8'hFF, 1'b0, 8'h00, "R9 acc reset");
    // short-address registers
    access(8'h80, 1'b1, 8'h11, "R5 write X");
    access(8'h81, 1'b1, 8'h22, "R5 write Y");
    access(8'h82, 1'b1, 8'h33, "R5 write V");
    access(8'h83, 1'b1, 8'h44, "R5 write W");
    access(8'h80, 1'b0, 8'h00, "R5 read X");
    access(8'h81, 1'b0, 8'h00, "R5 read Y");
    access(8'h82, 1'b0, 8'h00, "R5 read V");
    access(8'h83, 1'b0, 8'h00, "R5 read W");
    // RAM body, top edge, read-first
    access(8'h90, 1'b1, 8'hA5, "R4 write 90");
    access(8'hBF, 1'b1, 8'h5A, "R4 write BF");
    access(8'h90, 1'b0, 8'h00, "R4 read 90");
    access(8'hBF, 1'b0, 8'h00, "R4 read BF");
    access(8'h90, 1'b1, 8'h77, "R4 read-first old value");
    access(8'h90, 1'b0, 8'h00, "R4 read new value");
    // unimplemented region
    access(8'h10, 1'b1, 8'h00, "R1 write ignored");
    access(8'h10, 1'b0, 8'h00, "R1 read 10");
    access(8'h90, 1'b0, 8'h00, "R1 alias RAM untouched");
    access(8'h00, 1'b0, 8'h00, "R1 read 00");
    access(8'h3F, 1'b0, 8'h00, "R1 read 3F");
    access(BANK_A, 1'b0, 8'h00, "R1 bank untouched");
    // window, bank 0
    access(8'h40, 1'b0, 8'h00, "R2 window 40");
    access(8'h7F, 1'b0, 8'h00, "R2 window 7F");
    // window writes ignored
    access(8'h50, 1'b1, 8'h00, "R3 write window");
    access(8'h50, 1'b0, 8'h00, "R3 window still rom");
    access(8'h90, 1'b0, 8'h00, "R3 alias RAM untouched");
    access(BANK_A, 1'b0, 8'h00, "R3 bank untouched");
    // bank switching, back to back
    access(BANK_A, 1'b1, 8'h2A, "R6 write bank");
    access(8'h45, 1'b0, 8'h00, "R6 window next access");
    access(BANK_A, 1'b0, 8'h00, "R6 read bank");
    access(BANK_A, 1'b1, 8'hFF, "R6 write bank wide");
    access(8'h7E, 1'b0, 8'h00, "R6 window bank 3F");
    access(BANK_A, 1'b0, 8'h00, "R6 read bank 3F");
    // accumulator
    access(8'hFF, 1'b1, 8'h9C, "R7 write acc");
    access(8'hFF, 1'b0, 8'h00, "R7 read acc");
    access(8'hFF, 1'b1, 8'h01, "R7 read-first acc");
    access(8'hFF, 1'b0, 8'h00, "R7 read acc new");
    // peripherals
    access(8'hC0, 1'b0, 8'h00, "R8 periph C0");
    access(8'hC7, 1'b1, 8'h12, "R8 periph C7");
    access(8'hFE, 1'b0, 8'h00, "R8 periph FE");
    access(8'hC9, 1'b0, 8'h00, "R8 periph C9");
    @(negedge clk);
    wr_en = 1'b0;
    addr = 8'h00;
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule